// File: doc/BRIEF.md
# Frame-Counted Pixel Blink Unit

This block sits inline in a video pixel pipeline and makes chosen pixel values blink. A frame-start strobe advances a frame counter. One shared blink phase flips each time a programmed number of frames has passed. That number is the rate field's all-ones value minus the rate field. With the 8-bit default this is 255 minus the rate, so a full on/off cycle lasts twice that many frames.

A pixel takes part in blinking when its value equals a programmed pattern on every bit that a programmed mask selects. While the phase is in its blinked state, every such pixel is replaced by a programmable blink value. All other pixels pass through unchanged. The pixel path is registered and has one clock of latency, and its valid flag is delayed to match.

Top module: `pixel_blink_unit`

## Requirements
- R1: While rst_ni is low, pix_o reads 0 and pix_valid_o reads 0. The blink phase starts in the non-blinked state and the frame count starts at 0.
- R2: Let N = 255 - blink_rate_i, with N nonzero. The frame count advances on each clock edge at which frame_start_i is high. On the strobe where the count is already at N-1 or above, the count returns to 0 and the blink phase inverts. Without a strobe, the phase and the count hold.
- R3: While blink_rate_i is 255, each clock edge forces the phase to non-blinked and the count to 0, so no pixel is replaced.
- R4: A pixel matches when (pix_i & mask_i) == (pattern_i & mask_i). An all-zero mask makes every pixel match.
- R5: A valid pixel accepted while the phase is blinked, if it matches, appears on pix_o one clock later as blink_value_i.
- R6: A valid pixel that does not match, or that is accepted while the phase is non-blinked, appears unchanged on pix_o one clock later.
- R7: pix_valid_o equals pix_valid_i delayed by one clock.
- R8: When pix_valid_i is low, pix_o keeps its previous value.
- R9: A pixel accepted on the same edge as a frame-start strobe is judged with the phase in force before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle strobe at the start of each video frame |
| blink_rate_i | input | RATE_W | Rate field; the phase toggles every (all-ones - rate) frames |
| pattern_i | input | PIX_W | Pixel value that selects blink pixels |
| mask_i | input | PIX_W | Bits of the pixel that take part in the comparison |
| blink_value_i | input | PIX_W | Value substituted for blink pixels in the blinked phase |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | PIX_W | Input pixel |
| pix_valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | PIX_W | Output pixel |

## Verification
The bench builds the block with PIX_W = 16 and the default 8-bit rate. At that width, pixels forced onto the pattern with random don't-care bits are a realistic share of the traffic. The 8-bit rate lets a back-to-back strobe run with rate 0 reach the longest toggle period of 255 frames. Rates 250 to 255 keep the random part busy with frequent toggles, mid-count rate changes and the disabled setting. Strobes that fall on accepted pixels exercise the same-edge ordering.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic {
    PH_NORMAL = 1'b0,
    PH_BLINK  = 1'b1
  } blink_phase_e;
endpackage

// File: rtl/blink_phase_gen.sv
module blink_phase_gen
  import blink_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [RATE_W-1:0] blink_rate_i,
  output blink_phase_e      phase_o
);
  localparam logic [RATE_W-1:0] RATE_MAX = '1;

  logic [RATE_W-1:0] period, last, cnt_q;
  blink_phase_e      phase_q;

  assign period = RATE_MAX - blink_rate_i;
  assign last   = period - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_NORMAL;
    end else if (period == '0) begin
      cnt_q   <= '0;
      phase_q <= PH_NORMAL;
    end else if (frame_start_i) begin
      // >= keeps a lowered period from running the count past its end
      if (cnt_q >= last) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_BLINK) ? PH_NORMAL : PH_BLINK;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;

  a_r2_phase_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> (phase_q == $past(phase_q)) || (phase_q == PH_NORMAL));

  a_r2_count_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0));

  a_r3_rate_max_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_rate_i == RATE_MAX) |=> (phase_q == PH_NORMAL) && (cnt_q == '0));
endmodule

// File: rtl/blink_match.sv
module blink_match #(
  parameter int PIX_W = 24
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] pattern_i,
  input  logic [PIX_W-1:0] mask_i,
  output logic             match_o
);
  logic [PIX_W-1:0] miss;

  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    assign miss[b] = mask_i[b] & (pix_i[b] ^ pattern_i[b]);
  end

  assign match_o = ~|miss;
endmodule

// File: rtl/blink_out_stage.sv
module blink_out_stage
  import blink_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             match_i,
  input  blink_phase_e     phase_i,
  input  logic [PIX_W-1:0] blink_value_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o
);
  logic             swap;
  logic [PIX_W-1:0] pix_d;

  assign swap  = match_i && (phase_i == PH_BLINK);
  assign pix_d = swap ? blink_value_i : pix_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pix_o <= pix_d;
    end
  end

  a_r5_blink_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && match_i && phase_i == PH_BLINK) |=> pix_o == $past(blink_value_i));

  a_r6_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (!match_i || phase_i == PH_NORMAL)) |=> pix_o == $past(pix_i));

  a_r7_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pix_o));
endmodule

// File: rtl/pixel_blink_unit.sv
module pixel_blink_unit
  import blink_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [RATE_W-1:0] blink_rate_i,
  input  logic [PIX_W-1:0]  pattern_i,
  input  logic [PIX_W-1:0]  mask_i,
  input  logic [PIX_W-1:0]  blink_value_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o
);
  blink_phase_e phase;
  logic         match;

  blink_phase_gen #(.RATE_W(RATE_W)) i_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .blink_rate_i (blink_rate_i),
    .phase_o      (phase)
  );

  blink_match #(.PIX_W(PIX_W)) i_match (
    .pix_i    (pix_i),
    .pattern_i(pattern_i),
    .mask_i   (mask_i),
    .match_o  (match)
  );

  blink_out_stage #(.PIX_W(PIX_W)) i_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (pix_valid_i),
    .pix_i        (pix_i),
    .match_i      (match),
    .phase_i      (phase),
    .blink_value_i(blink_value_i),
    .valid_o      (pix_valid_o),
    .pix_o        (pix_o)
  );

  // R4: a zero mask must always produce a match
  a_r4_zero_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> match);
endmodule

// File: tb/test_pixel_blink_unit.sv
module test_pixel_blink_unit;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_start_i = 1'b0;
  logic [7:0]    blink_rate_i = 8'd255;
  logic [PW-1:0] pattern_i = '0, mask_i = '0, blink_value_i = '0, pix_i = '0;
  logic          pix_valid_i = 1'b0;
  logic          pix_valid_o;
  logic [PW-1:0] pix_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  bit m_phase = 0;
  int m_cnt = 0;
  logic [PW-1:0] m_pix = '0;
  string sect = "R1";

  always #5ns clk_i = ~clk_i;

  pixel_blink_unit #(.PIX_W(PW), .RATE_W(8)) i_pixel_blink_unit (.*);

  function automatic bit m_match(logic [PW-1:0] p);
    return ((p ^ pattern_i) & mask_i) == '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs driven at negedge, outputs sampled 1 ns after the posedge
  task automatic step(bit v, logic [PW-1:0] p, bit fs);
    string tag;
    int n;
    pix_valid_i = v; pix_i = p; frame_start_i = fs;
    if (v) begin
      if (m_phase && m_match(p)) begin m_pix = blink_value_i; tag = "R5"; end
      else begin m_pix = p; tag = "R6"; end
      if (fs) tag = {tag, "/R9"};
    end else tag = "R8";
    n = 255 - int'(blink_rate_i);
    if (n == 0) begin m_phase = 0; m_cnt = 0; end
    else if (fs) begin
      if (m_cnt >= n - 1) begin m_cnt = 0; m_phase = ~m_phase; end
      else m_cnt++;
    end
    @(posedge clk_i); #1ns;
    check({sect, " ", tag, " pix"}, 32'(pix_o), 32'(m_pix));
    check({sect, " R7 valid"}, 32'(pix_valid_o), 32'(v));
    @(negedge clk_i);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] r;
    repeat (3) @(negedge clk_i);
    check("R1 pix reset", 32'(pix_o), 32'h0);
    check("R1 valid reset", 32'(pix_valid_o), 32'h0);
    rst_ni = 1'b1;

    // R1: phase starts non-blinked, a matching pixel passes
    blink_rate_i = 8'd254; mask_i = 16'hFFFF; pattern_i = 16'h0A5A; blink_value_i = 16'h7FFF;
    step(1, 16'h0A5A, 0);

    // R2: N=1, phase flips on every strobe
    sect = "R2";
    for (int i = 0; i < 6; i++) begin
      step(0, 16'h1111, 1);
      step(1, 16'h0A5A, 0);
      step(1, 16'h0A5B, 0);
    end
    // R2: N=3
    blink_rate_i = 8'd252;
    for (int i = 0; i < 10; i++) begin
      step(0, 16'h0, 1);
      step(1, 16'h0A5A, 0);
    end
    // R2: longest period, rate 0 -> 255 strobes per toggle
    blink_rate_i = 8'd0;
    for (int i = 0; i < 600; i++) step(1, 16'h0A5A, 1);

    // R3: rate 255 forces non-blinked at once and ignores strobes
    sect = "R3";
    blink_rate_i = 8'd254;
    step(0, 16'h0, 1);
    if (!m_phase) step(0, 16'h0, 1);
    blink_rate_i = 8'd255;
    step(1, 16'h0A5A, 0);
    for (int i = 0; i < 5; i++) step(1, 16'h0A5A, 1);

    // R4: zero mask matches all; partial mask
    sect = "R4";
    blink_rate_i = 8'd254;
    step(0, 16'h0, 1);
    mask_i = 16'h0000;
    step(1, 16'h1234, 0);
    step(1, 16'hFFFF, 0);
    mask_i = 16'hFF00; pattern_i = 16'hAB00;
    step(1, 16'hAB77, 0);
    step(1, 16'hAC77, 0);

    // R9: strobe and pixel on the same edge
    sect = "R9";
    step(1, 16'hAB01, 1);
    step(1, 16'hAB02, 1);

    // R8: idle cycles hold the output
    sect = "R8";
    step(0, 16'hDEAD, 0);
    step(0, 16'hBEEF, 1);

    // random mix: R5/R6
    sect = "RND";
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        blink_rate_i  = 8'(250 + $urandom_range(0, 5));
        mask_i        = PW'($urandom);
        pattern_i     = PW'($urandom);
        blink_value_i = PW'($urandom);
      end
      r = PW'($urandom);
      if ($urandom_range(0, 1) == 1) r = (pattern_i & mask_i) | (r & ~mask_i);
      step($urandom_range(0, 3) != 0, r, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule